// File: doc/BRIEF.md
# Wait-State Register Slave

This block is a memory-mapped slave on a pipelined two-phase bus. It holds a small file of data-width registers. Each transfer starts with an address phase, in which the slave captures the register index, the direction and the transfer kind. The transfer then finishes in the data phase that follows. The slave can lengthen its own data phase by a fixed, parameterised number of wait states, which it signals by pulling its ready output low.

Every slave's ready output feeds a system-wide AND, and that AND comes back to each slave as its ready input. A low ready input means some data phase on the bus is still being stretched. Any address phase that overlaps it is therefore not yet valid. The slave accepts its select only on a clock edge where the ready input is high. If another slave stalls the bus, a select held across the stall is taken at the first edge after ready rises, not before.

Write data is stored on the last data-phase cycle. Read data is driven during that same cycle. Idle and busy transfer kinds finish with no wait and touch no register.

Top module: `waitStateSlave`

## Requirements
- R1: After reset, readyOut is high, rdataOut is zero and every register reads back as zero.
- R2: A transfer is accepted on a rising clock edge where selIn and readyIn are both high and transIn is 2'b10 (first beat) or 2'b11 (following beat). The register is chosen by addrIn[IDX_W+1:2], which is bits 4:2 with the default parameters. All other address bits are ignored, so addresses 32 bytes apart alias.
- R3: After acceptance, readyOut is low for exactly WAIT_STATES cycles and then high for the final data-phase cycle. With WAIT_STATES = 0 the data phase takes a single cycle.
- R4: When readyIn is low at an edge, no transfer is accepted, even with selIn high and a valid transIn. readyOut stays high and no register changes.
- R5: If selIn is held through a bus stall, the transfer is accepted at the first edge where readyIn is high. It then runs its full wait-state count from that point.
- R6: A write stores the wdataIn value present at the edge that ends the data phase, which is the edge where readyOut and readyIn are both high.
- R7: During the final cycle of a read data phase, rdataOut equals the addressed register. At all other times it is zero.
- R8: transIn values 2'b00 (idle) and 2'b01 (busy) are accepted with no wait state. They cause no register access, and readyOut stays high.
- R9: The data phase ends only on an edge where readyIn is high. If readyIn is low during the slave's final cycle, the phase holds for another cycle and the write data is taken later.
- R10: A new address phase presented during this slave's data phase is accepted at the edge that ends the current phase. A read of the register just written returns the new value.
- R11: When selIn is low, the slave starts no transfer and readyOut stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| selIn | input | 1 | Slave select for the current address phase |
| addrIn | input | ADDR_W | Byte address of the transfer |
| transIn | input | 2 | Transfer kind: 00 idle, 01 busy, 10 first beat, 11 following beat |
| writeIn | input | 1 | 1 for write, 0 for read |
| wdataIn | input | DATA_W | Write data during the data phase |
| rdataOut | output | DATA_W | Read data, valid in the final data-phase cycle |
| readyIn | input | 1 | System-wide AND of all slaves' ready outputs |
| readyOut | output | 1 | Low while this slave is stretching its data phase |

## Verification
The main corner case is a select that arrives while the bus is stalled. A slave that ignored readyIn would start a data phase in the middle of another slave's stretched phase. Its readyOut would drop early, and it would write a register the bench then finds changed.

The bench also stalls the bus on the slave's own final cycle. A design that completed on its own readyOut alone would latch the stale write data. A back-to-back write then read of the same register catches a design that captures the next address late or reads before the write lands.

Idle and busy kinds, and aliased addresses, are swept. Any stray register access or a wrong index decode shows up as a wrong read-back value.

// File: rtl/waitSlavePkg.sv
package waitSlavePkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } transKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch address this edge
    logic wrEn;     // store write data this edge
    logic rdEn;     // drive read data this cycle
  } slvStrobe_t;

endpackage

// File: rtl/wsCtrl.sv
module wsCtrl
  import waitSlavePkg::*;
#(
  parameter int WAIT_STATES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selIn,
  input  logic [1:0] transIn,
  input  logic       writeIn,
  input  logic       readyIn,
  output logic       readyOut,
  output slvStrobe_t strb
);

  localparam int CNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_STATES);

  logic             activeQ;
  logic             writeQ;
  logic [CNT_W-1:0] cntQ;

  logic kindValid;
  logic addrValid;
  logic finalCyc;
  logic phaseDone;

  assign kindValid = (transIn == TR_NONSEQ) || (transIn == TR_SEQ);
  // an address phase only counts on an edge where the whole bus is ready
  assign addrValid = selIn && readyIn && kindValid;
  assign finalCyc  = activeQ && (cntQ == '0);
  assign phaseDone = finalCyc && readyIn;
  assign readyOut  = !activeQ || (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      writeQ  <= 1'b0;
      cntQ    <= '0;
    end else if (addrValid) begin
      activeQ <= 1'b1;
      writeQ  <= writeIn;
      cntQ    <= CNT_LOAD;
    end else if (phaseDone) begin
      activeQ <= 1'b0;
    end else if (activeQ && (cntQ != '0)) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  assign strb.capture = addrValid;
  assign strb.wrEn    = phaseDone && writeQ;
  assign strb.rdEn    = finalCyc && !writeQ;

  // R3: an accepted transfer with wait states drops ready next cycle
  p_wait_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((WAIT_STATES > 0) && strb.capture) |=> !readyOut);

  // R3: the wait counter steps down by one each stretched cycle
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && (cntQ != '0) && !strb.capture) |=> (activeQ && (cntQ == $past(cntQ) - 1'b1)));

  // R4: a low bus ready never starts a data phase
  p_no_start_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!readyIn && !activeQ) |=> !activeQ);

  // R4: captured direction is frozen while the bus is stalled
  p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !readyIn |=> $stable(writeQ));

  // R6: a store only happens with both ready signals high
  p_wr_final_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> (readyOut && readyIn));

  // R8 / R11: no valid select keeps ready high
  p_idle_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    (readyIn && readyOut && !(selIn && kindValid)) |=> readyOut);

endmodule

// File: rtl/wsRegs.sv
module wsRegs
  import waitSlavePkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  slvStrobe_t        strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wdataIn,
  output logic [DATA_W-1:0] rdataOut
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] idxNext;
  logic [NUM_REGS-1:0][DATA_W-1:0] regFlat;

  // word index: drop the two byte-offset bits, keep IDX_W bits
  assign idxNext = IDX_W'(addrIn >> 2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (strb.capture) begin
      idxQ <= idxNext;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= '0;
      end else if (strb.wrEn && (idxQ == IDX_W'(g))) begin
        q <= wdataIn;
      end
    end
    assign regFlat[g] = q;
  end

  assign rdataOut = strb.rdEn ? regFlat[idxQ] : '0;

  // R6: the addressed register holds the data present at the store edge
  p_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> (regFlat[$past(idxQ)] == $past(wdataIn)));

  // R8: without a store strobe the register file does not move
  p_no_access_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> $stable(regFlat));

endmodule

// File: rtl/waitStateSlave.sv
module waitStateSlave
  import waitSlavePkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int NUM_REGS    = 8,
  parameter int WAIT_STATES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [1:0]        transIn,
  input  logic              writeIn,
  input  logic [DATA_W-1:0] wdataIn,
  output logic [DATA_W-1:0] rdataOut,
  input  logic              readyIn,
  output logic              readyOut
);

  slvStrobe_t strb;

  wsCtrl #(
    .WAIT_STATES(WAIT_STATES)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .selIn   (selIn),
    .transIn (transIn),
    .writeIn (writeIn),
    .readyIn (readyIn),
    .readyOut(readyOut),
    .strb    (strb)
  );

  wsRegs #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NUM_REGS(NUM_REGS)
  ) uRegs (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addrIn  (addrIn),
    .wdataIn (wdataIn),
    .rdataOut(rdataOut)
  );

  // R7: read data is quiet whenever this slave stretches its phase
  p_rd_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !readyOut |-> (rdataOut == '0));

endmodule

// File: tb/waitStateSlave_test.sv
module waitStateSlave_test;

  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NR = 8;
  localparam int WS = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          selIn = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [1:0]    transIn = 2'b00;
  logic          writeIn = 1'b0;
  logic [DW-1:0] wdataIn = '0;
  logic [DW-1:0] rdataOut;
  logic          readyIn;
  logic          readyOut;
  logic          extReady = 1'b1;

  int vecs = 0;
  int errs = 0;

  always #4 clk = ~clk;

  // system-wide AND: this slave plus a model of all others
  assign readyIn = readyOut & extReady;

  waitStateSlave #(
    .DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR), .WAIT_STATES(WS)
  ) uut (
    .clk(clk), .rstN(rstN), .selIn(selIn), .addrIn(addrIn),
    .transIn(transIn), .writeIn(writeIn), .wdataIn(wdataIn),
    .rdataOut(rdataOut), .readyIn(readyIn), .readyOut(readyOut)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return (32'h1000_0001 * (i + 1)) ^ 32'hC3C3_0000;
  endfunction

  // called just after a falling edge; returns read data and wait count
  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd, output int waits);
    selIn = 1'b1; transIn = 2'b10; writeIn = wr; addrIn = a;
    @(negedge clk);
    selIn = 1'b0; transIn = 2'b00; writeIn = 1'b0; wdataIn = d;
    waits = 0;
    #2;
    while (!readyOut) begin
      waits++;
      @(negedge clk);
      #2;
    end
    rd = rdataOut;
    @(negedge clk);
    wdataIn = '0;
  endtask

  logic [DW-1:0] rd;
  int            w;
  logic [DW-1:0] mirror [NR];

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired before all requirements were checked");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    check("R1 readyOut after reset", {31'd0, readyOut}, 32'd1);
    check("R1 rdataOut after reset", rdataOut, '0);
    @(negedge clk);

    // R1 / R3 / R7: every register reads zero, each read takes WS waits
    for (int i = 0; i < NR; i++) begin
      xfer(1'b0, AW'(i * 4), '0, rd, w);
      check("R1 reset register value", rd, '0);
      check("R3 read wait count", w, WS);
      mirror[i] = '0;
    end

    // R2 / R6: write all registers through base addresses
    for (int i = 0; i < NR; i++) begin
      xfer(1'b1, AW'(i * 4), pat(i), rd, w);
      check("R3 write wait count", w, WS);
      mirror[i] = pat(i);
    end
    for (int i = 0; i < NR; i++) begin
      xfer(1'b0, AW'(i * 4), '0, rd, w);
      check("R7 read back base", rd, mirror[i]);
    end

    // R2: aliased addresses (upper bits and byte offset ignored)
    for (int i = 0; i < NR; i++) begin
      xfer(1'b1, AW'(i * 4 + NR * 4 + (i % 4)), ~pat(i), rd, w);
      mirror[i] = ~pat(i);
    end
    for (int i = 0; i < NR; i++) begin
      xfer(1'b0, AW'(i * 4 + 2 * NR * 4), '0, rd, w);
      check("R2 aliased index decode", rd, mirror[i]);
    end

    // R4: select with bus stalled is ignored
    extReady = 1'b0;
    selIn = 1'b1; transIn = 2'b10; writeIn = 1'b1; addrIn = AW'(3 * 4); wdataIn = 32'hDEAD_0004;
    @(negedge clk);
    #2;
    check("R4 readyOut high after stalled select", {31'd0, readyOut}, 32'd1);
    selIn = 1'b0; transIn = 2'b00; writeIn = 1'b0;
    @(negedge clk);
    extReady = 1'b1;
    wdataIn = '0;
    @(negedge clk);
    xfer(1'b0, AW'(3 * 4), '0, rd, w);
    check("R4 register untouched by stalled select", rd, mirror[3]);

    // R5: select held across stall is taken when ready rises
    extReady = 1'b0;
    selIn = 1'b1; transIn = 2'b11; writeIn = 1'b1; addrIn = AW'(4 * 4);
    @(negedge clk);
    #2;
    check("R5 no phase during stall", {31'd0, readyOut}, 32'd1);
    @(negedge clk);
    extReady = 1'b1;
    @(negedge clk);
    selIn = 1'b0; transIn = 2'b00; writeIn = 1'b0; wdataIn = 32'h5555_AAAA;
    w = 0;
    #2;
    while (!readyOut && w < 10) begin
      w++;
      @(negedge clk);
      #2;
    end
    check("R5 wait count after ready rise", w, WS);
    @(negedge clk);
    wdataIn = '0;
    mirror[4] = 32'h5555_AAAA;
    xfer(1'b0, AW'(4 * 4), '0, rd, w);
    check("R5 delayed write stored", rd, mirror[4]);

    // R9: bus stalled during own final cycle, later data wins
    selIn = 1'b1; transIn = 2'b10; writeIn = 1'b1; addrIn = AW'(5 * 4);
    @(negedge clk);
    selIn = 1'b0; transIn = 2'b00; writeIn = 1'b0; wdataIn = 32'hBAD0_BAD0;
    #2;
    while (!readyOut) begin
      @(negedge clk);
      #2;
    end
    extReady = 1'b0;
    @(negedge clk);
    extReady = 1'b1; wdataIn = 32'h0600_D009;
    #2;
    check("R9 phase held while bus stalled", {31'd0, readyOut}, 32'd1);
    @(negedge clk);
    wdataIn = '0;
    mirror[5] = 32'h0600_D009;
    xfer(1'b0, AW'(5 * 4), '0, rd, w);
    check("R9 write data taken at real completion", rd, mirror[5]);

    // R10: write then pipelined read of the same register
    selIn = 1'b1; transIn = 2'b10; writeIn = 1'b1; addrIn = AW'(2 * 4);
    @(negedge clk);
    writeIn = 1'b0; wdataIn = 32'h7777_0102;
    #2;
    while (!readyOut) begin
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    selIn = 1'b0; transIn = 2'b00; wdataIn = '0;
    w = 0;
    #2;
    while (!readyOut && w < 10) begin
      w++;
      @(negedge clk);
      #2;
    end
    check("R10 pipelined read wait count", w, WS);
    check("R10 pipelined read sees new data", rdataOut, 32'h7777_0102);
    mirror[2] = 32'h7777_0102;
    @(negedge clk);

    // R8: idle and busy kinds with select and write set
    for (int t = 0; t < 2; t++) begin
      selIn = 1'b1; transIn = 2'(t); writeIn = 1'b1; addrIn = '0; wdataIn = 32'hFFFF_0000;
      @(negedge clk);
      #2;
      check("R8 no wait for idle/busy", {31'd0, readyOut}, 32'd1);
      check("R8 no read data for idle/busy", rdataOut, '0);
      @(negedge clk);
      selIn = 1'b0; transIn = 2'b00; writeIn = 1'b0; wdataIn = '0;
      @(negedge clk);
      xfer(1'b0, '0, '0, rd, w);
      check("R8 register untouched by idle/busy", rd, mirror[0]);
    end

    // R11: valid kind but not selected
    selIn = 1'b0; transIn = 2'b10; writeIn = 1'b1; addrIn = AW'(6 * 4); wdataIn = 32'h1234_5678;
    @(negedge clk);
    #2;
    check("R11 readyOut high when unselected", {31'd0, readyOut}, 32'd1);
    @(negedge clk);
    transIn = 2'b00; writeIn = 1'b0; wdataIn = '0;
    xfer(1'b0, AW'(6 * 4), '0, rd, w);
    check("R11 register untouched when unselected", rd, mirror[6]);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule